// File: doc/BRIEF.md
# Interrupt Flag Unit with Indirect Mask

This unit collects eight event sources of a DMA channel into sticky flags and raises a single level interrupt when any flag that is not masked is set. Software clears flags by writing ones to them. The mask cannot be written directly. Two write-only command words change it instead: one unmasks the selected sources and the other masks them.

A small companion counter tracks completed transfers. It steps up on every completion event and steps down whenever software acknowledges a pending completion flag. It lives in bits [15:13] of a channel status word, which also reports a read-only busy indication taken from an input pin. Software can also clear the counter bits directly by writing ones to them.

The register interface is a plain 32-bit bus. Every access is one full word. Writes are qualified by a write strobe, and reads are combinational from the current address.

Top module: `irq_flag_unit`

## Requirements
- R1: Each bit of `evt_set` that is high at a clock edge sets the flag of the same index. The flag meanings by bit are: 7 FIFO overflow, 6 invalid register access, 5 threshold hit, 4 memory timeout, 3 stream timeout, 2 bus response error, 1 done, 0 memory done.
- R2: A write to the flag word (offset 0x00) clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R3: A write to the unmask command word (offset 0x04) clears each mask bit whose data bit is 1. Bits written as 0 have no effect. The word always reads 0.
- R4: A write to the mask command word (offset 0x08) sets each mask bit whose data bit is 1. Bits written as 0 have no effect. The word always reads 0.
- R5: The mask is visible read-only at offset 0x0C, and writes there are ignored. After reset the mask is 0xFF, the flags are 0 and the counter is 0.
- R6: `irq` is high exactly when some flag is set whose mask bit is 0. It reflects a write or an event from the clock edge that captures it.
- R7: The channel status word (offset 0x10) holds the done counter in bits [15:13] and the `chan_busy` input in bit 0; all other bits read 0. The counter increments on each cycle in which `evt_set[1]` is high.
- R8: The counter decrements by one when a flag-word write with bit 1 set finds the done flag set. There is no decrement when the done flag was already clear.
- R9: Writing 1s to bits [15:13] of the channel status word clears those counter bits. Such a clear wins over a same-cycle increment, and writes to bit 0 have no effect.
- R10: The counter wraps modulo 8 and changes by at most one per cycle, except when it is cleared.
- R11: When an event and a software clear hit the same flag in one cycle, the flag stays set. A same-cycle increment and decrement of the counter cancel.
- R12: Reads from any offset above 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Byte address of the word accessed |
| reg_we | input | 1 | Write strobe for the current address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| evt_set | input | 8 | Per-source event pulses |
| chan_busy | input | 1 | Busy indication reported in channel status |
| irq | output | 1 | Level interrupt |

## Verification
A flag or mask bit held in the wrong state shows up on `irq` at the next clock edge for any source that software has unmasked. It also shows up at once on `reg_rdata` whenever the flag or mask word is addressed. A counter that misses or doubles a step stays wrong from then on, because nothing resets it short of a clear. The bench therefore reads the channel status word right after each increment, decrement, cancellation, wrap and partial clear. Collisions between events and clears in the same cycle are driven explicitly, since they are the only points where the priority rule decides the result.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int unsigned SRC_N    = 8;
  localparam int unsigned CNT_BITS = 3;
  localparam int unsigned CNT_POS  = 13;
  localparam int unsigned DONE_IDX = 1;
  localparam int unsigned WORD_W   = 32;

  typedef enum logic [2:0] {
    W_FLAGS  = 3'd0,
    W_UNMASK = 3'd1,
    W_MASK   = 3'd2,
    W_MASKRO = 3'd3,
    W_CHST   = 3'd4
  } word_idx_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N        = 8,
  parameter int unsigned DONE_BIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         done_ack_o
);
  // A new event overrides a clear of the same bit.
  function automatic logic [N-1:0] flag_next(logic [N-1:0] cur,
                                             logic [N-1:0] set,
                                             logic [N-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= flag_next(flags_o, set_i, clr_i);
  end

  assign done_ack_o = flags_o[DONE_BIT] & clr_i[DONE_BIT];
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] unmask_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] mask_o
);
  function automatic logic [N-1:0] mask_next(logic [N-1:0] cur,
                                             logic [N-1:0] on,
                                             logic [N-1:0] off);
    return (cur & ~on) | off;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_o <= '1;
    else        mask_o <= mask_next(mask_o, unmask_i, mask_i);
  end
endmodule

// File: rtl/irq_done_count.sv
module irq_done_count #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] cnt_o
);
  function automatic logic [W-1:0] cnt_next(logic [W-1:0] cur, logic inc,
                                            logic dec, logic [W-1:0] clr);
    logic [W-1:0] r;
    if (|clr)            r = cur & ~clr;
    else if (inc && !dec) r = cur + W'(1);
    else if (dec && !inc) r = cur - W'(1);
    else                 r = cur;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_next(cnt_o, inc_i, dec_i, clr_i);
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_unit_pkg::*;
#(
  parameter int unsigned NSRC   = SRC_N,
  parameter int unsigned CNT_W  = CNT_BITS,
  parameter int unsigned CNT_LO = CNT_POS,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NSRC-1:0]   evt_set,
  input  logic              chan_busy,
  output logic              irq
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             wr_flags, wr_unmask, wr_mask, wr_chst;
  logic [NSRC-1:0]  flags, mask, clr_vec, unmask_vec, mask_vec;
  logic [CNT_W-1:0] cnt, cnt_clr;
  logic             done_evt, done_ack;

  assign widx      = reg_addr[ADDR_W-1:2];
  assign wr_flags  = reg_we && (widx == IDX_W'(W_FLAGS));
  assign wr_unmask = reg_we && (widx == IDX_W'(W_UNMASK));
  assign wr_mask   = reg_we && (widx == IDX_W'(W_MASK));
  assign wr_chst   = reg_we && (widx == IDX_W'(W_CHST));

  assign clr_vec    = wr_flags  ? reg_wdata[NSRC-1:0] : '0;
  assign unmask_vec = wr_unmask ? reg_wdata[NSRC-1:0] : '0;
  assign mask_vec   = wr_mask   ? reg_wdata[NSRC-1:0] : '0;
  assign cnt_clr    = wr_chst   ? reg_wdata[CNT_LO +: CNT_W] : '0;
  assign done_evt   = evt_set[DONE_IDX];

  irq_flag_bank #(.N(NSRC), .DONE_BIT(DONE_IDX)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set), .clr_i(clr_vec),
    .flags_o(flags), .done_ack_o(done_ack)
  );

  irq_mask_ctl #(.N(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .unmask_i(unmask_vec), .mask_i(mask_vec),
    .mask_o(mask)
  );

  irq_done_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(done_evt), .dec_i(done_ack),
    .clr_i(cnt_clr), .cnt_o(cnt)
  );

  assign irq = |(flags & ~mask);

  always_comb begin
    reg_rdata = '0;
    case (widx)
      IDX_W'(W_FLAGS):  reg_rdata[NSRC-1:0] = flags;
      IDX_W'(W_MASKRO): reg_rdata[NSRC-1:0] = mask;
      IDX_W'(W_CHST): begin
        reg_rdata[CNT_LO +: CNT_W] = cnt;
        reg_rdata[0]               = chan_busy;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk #(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_flags,
  input logic             wr_unmask,
  input logic             wr_mask,
  input logic             wr_chst,
  input logic [NSRC-1:0]  clr_vec,
  input logic [NSRC-1:0]  unmask_vec,
  input logic [NSRC-1:0]  mask_vec,
  input logic [NSRC-1:0]  evt_set,
  input logic [NSRC-1:0]  flags,
  input logic [NSRC-1:0]  mask,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cnt_clr,
  input logic             done_ack,
  input logic             done_evt,
  input logic             irq
);
  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flags |=> ((flags & $past(clr_vec & ~evt_set)) == '0));

  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((flags & $past(evt_set)) == $past(evt_set)));

  a_r3_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ((mask & $past(unmask_vec)) == '0));

  a_r4_mask_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> ((mask & $past(mask_vec)) == $past(mask_vec)));

  a_r5_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_unmask || wr_mask) |=> $stable(mask));

  a_r6_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  a_r8_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ack && !done_evt && !wr_chst) |=> (cnt == $past(cnt) - CNT_W'(1)));

  a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr == '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)
                         || cnt == $past(cnt) - CNT_W'(1)));
endmodule

bind irq_flag_unit irq_flag_unit_chk #(.NSRC(NSRC), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_flags(wr_flags), .wr_unmask(wr_unmask),
  .wr_mask(wr_mask), .wr_chst(wr_chst), .clr_vec(clr_vec),
  .unmask_vec(unmask_vec), .mask_vec(mask_vec), .evt_set(evt_set),
  .flags(flags), .mask(mask), .cnt(cnt), .cnt_clr(cnt_clr),
  .done_ack(done_ack), .done_evt(done_evt), .irq(irq)
);

// File: tb/test_irq_flag_unit.sv
module test_irq_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_set = '0;
  logic        chan_busy = 1'b0;
  logic        irq;

  int applied = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_flag_unit i_irq_flag_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .chan_busy(chan_busy), .irq(irq)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  ev;
    logic [4:0]  raddr;
    logic [31:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  // Offsets: 00 flags, 04 unmask, 08 mask, 0C mask readback, 10 channel status
  localparam vec_t VECS [14] = '{
    '{1'b0, 5'h00, 32'h0,    8'h80, 5'h00, 32'h80,   1'b0},  // R1 R6
    '{1'b1, 5'h04, 32'h80,   8'h00, 5'h0C, 32'h7F,   1'b1},  // R3 R6
    '{1'b1, 5'h08, 32'h80,   8'h00, 5'h0C, 32'hFF,   1'b0},  // R4
    '{1'b1, 5'h0C, 32'h0,    8'h00, 5'h0C, 32'hFF,   1'b0},  // R5
    '{1'b1, 5'h04, 32'h02,   8'h00, 5'h0C, 32'hFD,   1'b0},  // R3
    '{1'b0, 5'h00, 32'h0,    8'h02, 5'h10, 32'h2000, 1'b1},  // R7
    '{1'b0, 5'h00, 32'h0,    8'h02, 5'h00, 32'h82,   1'b1},  // R7 R1
    '{1'b1, 5'h00, 32'h02,   8'h00, 5'h00, 32'h80,   1'b0},  // R2 R8
    '{1'b1, 5'h00, 32'h02,   8'h00, 5'h10, 32'h2000, 1'b0},  // R8 no dec
    '{1'b0, 5'h00, 32'h0,    8'h02, 5'h10, 32'h4000, 1'b1},  // R7
    '{1'b1, 5'h00, 32'h02,   8'h02, 5'h00, 32'h82,   1'b1},  // R11 flag
    '{1'b0, 5'h00, 32'h0,    8'h00, 5'h10, 32'h4000, 1'b1},  // R11 cancel
    '{1'b1, 5'h00, 32'h80,   8'h00, 5'h00, 32'h02,   1'b1},  // R2
    '{1'b1, 5'h04, 32'h0,    8'h00, 5'h04, 32'h0,    1'b1}   // R3 reads 0
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    applied++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(logic we, logic [4:0] wa, logic [31:0] wd,
                      logic [7:0] ev, logic [4:0] ra);
    @(negedge clk);
    reg_we = we; reg_addr = wa; reg_wdata = wd; evt_set = ev;
    @(posedge clk);
    #1;
    reg_we = 1'b0; reg_wdata = '0; evt_set = '0; reg_addr = ra;
    #5;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // Reset state (R5)
    reg_addr = 5'h0C; #2; check("R5 mask reset", reg_rdata, 32'hFF);
    reg_addr = 5'h00; #2; check("R5 flags reset", reg_rdata, 32'h0);
    reg_addr = 5'h10; #2; check("R5 count reset", reg_rdata, 32'h0);
    check("R6 irq reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      step(VECS[i].we, VECS[i].waddr, VECS[i].wdata, VECS[i].ev, VECS[i].raddr);
      check($sformatf("vector %0d data", i), reg_rdata, VECS[i].exp_rd);
      check($sformatf("vector %0d R6 irq", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
    end

    // R10: counter at 2, six more done events wrap it to 0
    for (int k = 0; k < 6; k++) step(1'b0, 5'h00, 32'h0, 8'h02, 5'h10);
    check("R10 wrap", reg_rdata, 32'h0);
    for (int k = 0; k < 3; k++) step(1'b0, 5'h00, 32'h0, 8'h02, 5'h10);
    check("R7 count 3", reg_rdata, 32'h6000);
    // R9: clear bit 13 only, bit 0 write ignored
    step(1'b1, 5'h10, 32'h2001, 8'h00, 5'h10);
    check("R9 partial clear", reg_rdata, 32'h4000);
    // R9: clear wins over same-cycle increment
    step(1'b1, 5'h10, 32'hE000, 8'h02, 5'h10);
    check("R9 clear beats inc", reg_rdata, 32'h0);
    // R8: decrement from 0 wraps to 7 (flag 1 is set)
    step(1'b1, 5'h00, 32'h02, 8'h00, 5'h10);
    check("R8 dec wrap", reg_rdata, 32'hE000);
    // R7: busy reflected at bit 0
    chan_busy = 1'b1; #2;
    check("R7 busy", reg_rdata, 32'hE001);
    chan_busy = 1'b0;
    // R12: unmapped offset
    reg_addr = 5'h14; #2; check("R12 unmapped", reg_rdata, 32'h0);
    // R6: masking a set source drops irq
    step(1'b0, 5'h00, 32'h0, 8'h04, 5'h00);
    step(1'b1, 5'h04, 32'h04, 8'h00, 5'h00);
    check("R6 irq on", {31'b0, irq}, 32'h1);
    step(1'b1, 5'h08, 32'hFF, 8'h00, 5'h00);
    check("R6 irq off", {31'b0, irq}, 32'h0);
    check("R4 flags kept", reg_rdata, 32'h04);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule